// File: doc/BRIEF.md
# Compact 16-bit Register-File Processor Core

This block is a single-cycle processor core for a small 16-bit instruction set. Each clock edge fetches one instruction from an internal instruction store and decodes it. The same edge executes it, and then updates the eight-entry register file and the program counter. The instruction store is byte-addressed and holds 64 bytes, which is 32 instruction words. Outside logic fills it through a word write port, normally while reset is held. A combinational debug port reads any register so that register contents can be checked from outside.

Each instruction word has these fields. Bits 13:10 select the operation. Bit 9 enables the register write. Bits 8:6 name the first source, bits 5:3 the second source and bits 2:0 the destination. Bits 15:14 are ignored. Branches and the jump take an absolute 6-bit byte target from bits 5:0. An all-zero operand field together with opcode 0xF stops the core. It then stays stopped until reset.

Top module: `tiny16_core`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, pcOut is 0, halted is 0 and every register reads 0. Reset does not clear the instruction store.
- R2: Two-operand operations write rs1 op rs2 to the register in bits 2:0 when bit 9 is 1. The encodings are ADD=0x0, SUB=0x1 (rs1 minus rs2, modulo 2^16), XOR=0x5, OR=0x6 and AND=0x7. The first source is in bits 8:6, the second in bits 5:3 and the opcode in bits 13:10.
- R3: Single-operand operations read only the first source. SLL=0x2 shifts left by one, SRL=0x3 shifts right by one, and both fill the vacated bit with zero. INV=0x4 is bitwise NOT. INCR=0x8 adds one, modulo 2^16.
- R4: When bit 9 is 0, no register changes.
- R5: Every instruction that does not redirect the program counter advances it by 2, modulo 64 (62 wraps to 0).
- R6: BRZ (0x9) loads bits 5:0 into the program counter when the first source reads zero. Otherwise it advances by 2. It never writes a register.
- R7: BLEZ (0xA) loads bits 5:0 into the program counter when the first source, read as signed, is zero or negative. Otherwise it advances by 2. It never writes a register.
- R8: JUMP (0xE) always loads bits 5:0 into the program counter and writes no register.
- R9: Opcode 0xF with bits 9:0 all zero sets halted from the next cycle. From then on the program counter and all registers hold until reset.
- R10: Opcodes 0xB, 0xC and 0xD, and opcode 0xF with any nonzero bit in 9:0, write no register and advance the program counter by 2.
- R11: A write with imemWe high stores imemWdata at instruction word imemAddr[5:1]. The fetch reads word pcOut[5:1].
- R12: dbgData shows, without delay, the register selected by dbgSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| imemWe | input | 1 | Instruction store write enable |
| imemAddr | input | 6 | Byte address of the word to write (bit 0 ignored) |
| imemWdata | input | 16 | Instruction word to store |
| dbgSel | input | 3 | Register index for the debug read |
| dbgData | output | 16 | Contents of the selected register |
| pcOut | output | 6 | Current program counter (byte address) |
| halted | output | 1 | High once the core has stopped |

## Verification
The assertions assume that the instruction store holds a known word at every fetched address once reset is released. This is why the stimulus writes all 32 words of each program while rstN is low and never writes the store while the core runs. They also assume a single synchronous reset: the bench holds rstN low across whole clock edges and drops it only on a falling edge. The stimulus covers every defined opcode and several undefined ones. It includes branches taken and not taken, with signed negative, zero and positive sources, a run through the top of the address space, and a reset in the middle of a run.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;
  localparam int INSTR_W = 16;
  localparam int SEL_W   = 3;
  localparam int TGT_W   = 6;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_SLL  = 4'h2,
    OP_SRL  = 4'h3,
    OP_INV  = 4'h4,
    OP_XOR  = 4'h5,
    OP_OR   = 4'h6,
    OP_AND  = 4'h7,
    OP_INCR = 4'h8,
    OP_BRZ  = 4'h9,
    OP_BLEZ = 4'hA,
    OP_JUMP = 4'hE,
    OP_HALT = 4'hF
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [3:0]       aluOp;
    logic             regWe;
    logic [SEL_W-1:0] src1;
    logic [SEL_W-1:0] src2;
    logic [SEL_W-1:0] dst;
  } dpCtrl_t;
endpackage

// File: rtl/tiny16_imem.sv
module tiny16_imem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [WORD_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [WORD_W-1:0] rData
);
  localparam int WORDS = 2 ** (ADDR_W - 1);

  logic [WORD_W-1:0] mem [WORDS];

  // Byte addresses, two bytes per word: bit 0 never selects a word
  always_ff @(posedge clk) begin
    if (we) mem[wAddr[ADDR_W-1:1]] <= wData;
  end

  assign rData = mem[rAddr[ADDR_W-1:1]];
endmodule

// File: rtl/tiny16_ctrl.sv
module tiny16_ctrl
  import tiny16_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic               src1Zero,
  input  logic               src1Neg,
  output dpCtrl_t            ctl,
  output logic [ADDR_W-1:0]  pc,
  output logic               halted
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  logic [3:0]        op;
  logic              wbBit;
  logic              isAlu;
  logic              isHalt;
  logic              takeBranch;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pcNext;

  assign op     = instr[13:10];
  assign wbBit  = instr[9];
  assign target = ADDR_W'(instr[TGT_W-1:0]);
  assign isAlu  = (op <= OP_INCR);
  assign isHalt = (op == OP_HALT) && (instr[9:0] == '0);

  always_comb begin
    case (op)
      OP_BRZ:  takeBranch = src1Zero;
      OP_BLEZ: takeBranch = src1Zero || src1Neg;
      OP_JUMP: takeBranch = 1'b1;
      default: takeBranch = 1'b0;
    endcase
  end

  always_comb begin
    ctl.aluOp = op;
    ctl.regWe = !halted && isAlu && wbBit;
    ctl.src1  = instr[8:6];
    ctl.src2  = instr[5:3];
    ctl.dst   = instr[2:0];
  end

  always_comb begin
    if (halted || isHalt) pcNext = pc;
    else if (takeBranch)  pcNext = target;
    else                  pcNext = pc + PC_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      halted <= 1'b0;
    end else begin
      pc <= pcNext;
      if (isHalt) halted <= 1'b1;
    end
  end

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pc)));

  p_halt_enter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && op == OP_HALT && instr[9:0] == '0) |=> (halted && $stable(pc)));

  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && (isAlu || op == OP_HALT && instr[9:0] != '0 ||
                 op == 4'hB || op == 4'hC || op == 4'hD))
    |=> (pc == $past(pc) + PC_STEP));

  p_jump_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && op == OP_JUMP) |=> (pc == $past(target)));

  p_brz_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && op == OP_BRZ && src1Zero) |=> (pc == $past(target)));

  p_blez_neg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && op == OP_BLEZ && src1Neg) |=> (pc == $past(target)));

  p_branch_nowrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    (op >= OP_BRZ) |-> !ctl.regWe);
endmodule

// File: rtl/tiny16_dpath.sv
module tiny16_dpath
  import tiny16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [SEL_W-1:0]  dbgSel,
  output logic [DATA_W-1:0] dbgData,
  output logic              src1Zero,
  output logic              src1Neg
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [REG_CNT-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] aluResult;

  assign opA = regs[ctl.src1];
  assign opB = regs[ctl.src2];

  assign src1Zero = (opA == '0);
  assign src1Neg  = opA[DATA_W-1];
  assign dbgData  = regs[dbgSel];

  always_comb begin
    case (ctl.aluOp)
      OP_ADD:  aluResult = opA + opB;
      OP_SUB:  aluResult = opA - opB;
      OP_SLL:  aluResult = {opA[DATA_W-2:0], 1'b0};
      OP_SRL:  aluResult = {1'b0, opA[DATA_W-1:1]};
      OP_INV:  aluResult = ~opA;
      OP_XOR:  aluResult = opA ^ opB;
      OP_OR:   aluResult = opA | opB;
      OP_AND:  aluResult = opA & opB;
      OP_INCR: aluResult = opA + ONE;
      default: aluResult = '0;
    endcase
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                                  regs[g] <= '0;
      else if (ctl.regWe && ctl.dst == SEL_W'(g)) regs[g] <= aluResult;
    end
  end

  p_wb_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.regWe |=> (regs[$past(ctl.dst)] == $past(aluResult)));

  p_nowb_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.regWe |=> $stable(regs));

  p_incr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWe && ctl.aluOp == OP_INCR) |=>
      (regs[$past(ctl.dst)] == $past(opA) + ONE));
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              imemWe,
  input  logic [ADDR_W-1:0] imemAddr,
  input  logic [15:0]       imemWdata,
  input  logic [2:0]        dbgSel,
  output logic [DATA_W-1:0] dbgData,
  output logic [ADDR_W-1:0] pcOut,
  output logic              halted
);
  logic [INSTR_W-1:0] instr;
  logic               src1Zero;
  logic               src1Neg;
  dpCtrl_t            ctl;

  tiny16_imem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) imem_i (
    .clk(clk), .we(imemWe), .wAddr(imemAddr), .wData(imemWdata),
    .rAddr(pcOut), .rData(instr)
  );

  tiny16_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .instr(instr), .src1Zero(src1Zero),
    .src1Neg(src1Neg), .ctl(ctl), .pc(pcOut), .halted(halted)
  );

  tiny16_dpath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dbgSel(dbgSel), .dbgData(dbgData),
    .src1Zero(src1Zero), .src1Neg(src1Neg)
  );
endmodule

// File: tb/tiny16_core_tb_top.sv
module tiny16_core_tb_top;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        imemWe;
  logic [5:0]  imemAddr;
  logic [15:0] imemWdata;
  logic [2:0]  dbgSel;
  logic [15:0] dbgData;
  logic [5:0]  pcOut;
  logic        halted;

  int total = 0;
  int bad   = 0;

  // Behavioural reference model
  logic [15:0] prog [32];
  int          mReg [8];
  int          mPc;
  bit          mHalted;
  string       regTag;
  string       pcTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny16_core dut_i (
    .clk(clk), .rstN(rstN), .imemWe(imemWe), .imemAddr(imemAddr),
    .imemWdata(imemWdata), .dbgSel(dbgSel), .dbgData(dbgData),
    .pcOut(pcOut), .halted(halted)
  );

  function automatic logic [15:0] enc(int op, int wb, int s1, int s2, int d);
    return {2'b00, 4'(op), 1'(wb), 3'(s1), 3'(s2), 3'(d)};
  endfunction

  function automatic logic [15:0] encB(int op, int s1, int tgt);
    return {2'b00, 4'(op), 1'b0, 3'(s1), 6'(tgt)};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    foreach (mReg[i]) mReg[i] = 0;
    mPc = 0; mHalted = 0;
    regTag = "R1"; pcTag = "R1";
  endtask

  task automatic modelStep();
    logic [15:0] ins;
    int op, a, b, res, tgt;
    bit wr, take;
    ins = prog[mPc / 2];
    op = int'(ins[13:10]);
    a = mReg[ins[8:6]]; b = mReg[ins[5:3]];
    tgt = int'(ins[5:0]);
    wr = 0; take = 0; res = 0;
    if (mHalted) begin regTag = "R9"; pcTag = "R9"; return; end
    regTag = "R2"; pcTag = "R5";
    case (op)
      0: res = a + b;
      1: res = a - b;
      2: begin res = a * 2; regTag = "R3"; end
      3: begin res = a / 2; regTag = "R3"; end
      4: begin res = ~a;    regTag = "R3"; end
      5: res = a ^ b;
      6: res = a | b;
      7: res = a & b;
      8: begin res = a + 1; regTag = "R3"; end
      9:  begin take = (a == 0); pcTag = "R6"; end
      10: begin take = (a == 0) || (a >= 32768); pcTag = "R7"; end
      14: begin take = 1; pcTag = "R8"; end
      default: begin regTag = "R10"; pcTag = "R10"; end
    endcase
    if (op <= 8) begin
      wr = ins[9];
      if (!wr) regTag = "R4";
    end
    if (op == 15 && ins[9:0] == 0) begin
      mHalted = 1; regTag = "R9"; pcTag = "R9"; return;
    end
    if (wr) mReg[ins[2:0]] = res & 16'hFFFF;
    mPc = take ? tgt : (mPc + 2) % 64;
  endtask

  // Sample away from the rising edge; debug reads step 1 time unit each (R12)
  task automatic compareAll();
    chk(pcTag, "pcOut", int'(pcOut), mPc);
    chk(mHalted ? "R9" : pcTag, "halted", int'(halted), int'(mHalted));
    for (int s = 0; s < 8; s++) begin
      dbgSel = 3'(s);
      #1;
      chk(regTag, $sformatf("reg%0d via debug port (R12)", s), int'(dbgData), mReg[s]);
    end
  endtask

  // R11: load all 32 words through the write port while reset is held
  task automatic loadAndRun(int cycles);
    @(negedge clk);
    rstN = 1'b0;
    for (int w = 0; w < 32; w++) begin
      imemWe = 1'b1; imemAddr = 6'(w * 2 + (w % 2)); imemWdata = prog[w];
      @(negedge clk);
    end
    imemWe = 1'b0;
    @(negedge clk);
    modelReset();
    compareAll();
    rstN = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      modelStep();
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; imemWe = 1'b0; imemAddr = '0; imemWdata = '0; dbgSel = '0;
    repeat (3) @(posedge clk);

    // Program A: ALU operations, write-back disable, undefined opcodes (R2 R3 R4 R10)
    foreach (prog[i]) prog[i] = 16'h3C00;
    prog[0]  = enc(8, 1, 0, 0, 1);
    prog[1]  = enc(4, 1, 0, 0, 2);
    prog[2]  = enc(0, 1, 1, 1, 3);
    prog[3]  = enc(2, 1, 3, 0, 4);
    prog[4]  = enc(3, 1, 2, 0, 5);
    prog[5]  = enc(1, 1, 1, 3, 6);
    prog[6]  = enc(5, 1, 2, 5, 7);
    prog[7]  = enc(6, 1, 4, 1, 3);
    prog[8]  = enc(7, 1, 2, 5, 4);
    prog[9]  = enc(8, 0, 1, 0, 1);
    prog[10] = enc(11, 1, 1, 1, 1);
    prog[11] = enc(13, 1, 2, 2, 2);
    prog[12] = enc(15, 1, 1, 0, 1);
    prog[13] = enc(2, 1, 2, 0, 6);
    prog[14] = 16'hFC00 | enc(3, 1, 7, 0, 0);
    prog[15] = 16'h3C00;
    loadAndRun(20);

    // Program B: branches and jump, signed tests (R6 R7 R8 R9)
    foreach (prog[i]) prog[i] = 16'h3C00;
    prog[0]  = enc(4, 1, 0, 0, 1);
    prog[1]  = encB(10, 1, 8);
    prog[2]  = enc(8, 1, 2, 0, 2);
    prog[3]  = 16'h3C00;
    prog[4]  = encB(9, 0, 14);
    prog[5]  = enc(8, 1, 0, 0, 6);
    prog[7]  = encB(9, 1, 4);
    prog[8]  = enc(8, 1, 0, 0, 3);
    prog[9]  = encB(10, 3, 4);
    prog[10] = encB(10, 0, 24);
    prog[11] = enc(8, 1, 0, 0, 7);
    prog[12] = enc(3, 1, 1, 0, 4);
    prog[13] = encB(10, 4, 4);
    prog[14] = encB(14, 0, 62);
    prog[31] = encB(14, 0, 4);
    prog[2]  = enc(8, 1, 2, 0, 2);
    loadAndRun(24);

    // Program C: straight-line code through the top of the address space (R5)
    foreach (prog[i]) prog[i] = enc(8, 1, 1, 0, 1);
    loadAndRun(40);

    // Mid-run reset: state returns to zero, store contents kept (R1)
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    modelReset();
    compareAll();
    rstN = 1'b1;
    for (int c = 0; c < 5; c++) begin
      modelStep();
      @(negedge clk);
      compareAll();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule